// File: doc/BRIEF.md
# General-Purpose Input Function Router

The router takes a bank of up to 32 general-purpose input pins and turns each one into a clean asserted level. First the pin passes through a two-flop synchronizer. Then its own polarity setting is applied: it is either active high or active low. A set of configuration vectors marks each pin as defined or not, and gives it one or more system roles. The roles are fault source, latched-status clear, margin enable, margin low/high select, and debug override. The router drives the matching system controls from those levels.

Fault sources raise a one-cycle event when they de-assert. Clear sources raise a one-cycle pulse when they assert. Margin enable and margin select each come from one pin only, and they produce a two-bit command for every rail. A debug pin turns off alert driving and fault handling, and it tells the sequencer to bypass its on/off dependency checks. The three lowest-numbered defined pins also form a 3-bit state-select code, whatever other roles they carry.

Top module: `gpi_router`

## Requirements
- R1: A pin change reaches the level-type outputs (state code, margin commands, debug controls) after exactly two rising clock edges; after one edge the outputs still show the old value.
- R2: When `pol_low_i[k]`=1, pin k counts as asserted while it is low. When `pol_low_i[k]`=0, it counts as asserted while it is high.
- R3: When a defined pin with `fault_sel_i[k]`=1 goes from asserted to de-asserted, bit k of `fault_evt_o` is high for exactly one cycle. The assertion edge raises no event.
- R4: When any defined pin with `clear_sel_i` set goes from de-asserted to asserted, `clear_pulse_o` is high for exactly one cycle. The de-assertion edge raises no pulse.
- R5: Margin enable follows only the lowest-numbered defined pin with `mgn_en_sel_i` set. Other pins marked for this role have no effect.
- R6: Rail r's command sits at `mgn_cmd_o[2r+1:2r]`. The codes are 2'b00 for nominal, 2'b01 for margin low and 2'b10 for margin high. The command is nominal whenever margin enable is de-asserted or `rail_mgn_en_i[r]`=0. Otherwise it is low while margin select is asserted and high while it is de-asserted.
- R7: Margin select follows only the lowest-numbered defined pin with `mgn_sel_sel_i` set. Other pins marked for this role have no effect.
- R8: Bit i of `state_code_o` is the asserted level of the (i+1)-th lowest-numbered defined pin, whatever that pin's roles are. If fewer than three pins are defined, the missing bits are 0.
- R9: While any defined debug pin is asserted, `alert_en_o` is 0, `dep_bypass_o` is 1 and `fault_evt_o` is all zero.
- R10: A pin with `pin_en_i[k]`=0 has no effect on any output and takes no slot in the state code.
- R11: For the first three cycles after reset release, no fault event and no clear pulse is produced, even if the synchronized levels change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Raw asynchronous input pins |
| pin_en_i | input | NUM_PINS | Pin is defined |
| pol_low_i | input | NUM_PINS | 1 = active low |
| fault_sel_i | input | NUM_PINS | Pin is a fault source |
| clear_sel_i | input | NUM_PINS | Pin clears latched statuses |
| mgn_en_sel_i | input | NUM_PINS | Candidate margin-enable pin |
| mgn_sel_sel_i | input | NUM_PINS | Candidate margin low/high select pin |
| debug_sel_i | input | NUM_PINS | Pin is a debug override |
| rail_mgn_en_i | input | NUM_RAILS | Margining allowed per rail |
| fault_evt_o | output | NUM_PINS | One-cycle fault events per pin |
| clear_pulse_o | output | 1 | One-cycle latched-status clear |
| mgn_cmd_o | output | 2*NUM_RAILS | Per-rail margin command |
| state_code_o | output | 3 | State-select code |
| alert_en_o | output | 1 | Alert driving allowed |
| dep_bypass_o | output | 1 | Sequencer ignores on/off dependencies |

## Verification
The assertions check on every cycle that:
- fault events and clear pulses never last longer than one cycle;
- no event comes from a pin that is not a defined fault source;
- debug mode blanks fault events and keeps its two control outputs complementary;
- no rail gets the unused command code, and a rail without margining stays nominal;
- events stay quiet during the post-reset arming window.

Only the bench scenarios can show the other behaviours:
- the two-edge latency;
- the polarity handling;
- the lowest-pin choice for the margin roles;
- the skipping of undefined pins when the state code is built;
- which edge direction fires each event.

// File: rtl/gpi_router_pkg.sv
package gpi_router_pkg;
  typedef enum logic [1:0] {
    MGN_NOMINAL = 2'b00,
    MGN_LOW     = 2'b01,
    MGN_HIGH    = 2'b10
  } mgn_cmd_e;

  localparam int unsigned CODE_W     = 3;
  localparam int unsigned ARM_CYCLES = 3;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpi_first_set.sv
module gpi_first_set #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] onehot_o
);
  always_comb begin
    logic found;
    found    = 1'b0;
    onehot_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i] && !found) begin
        onehot_o[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpi_code_pick.sv
module gpi_code_pick #(
  parameter int unsigned W     = 32,
  parameter int unsigned SLOTS = 3
) (
  input  logic [W-1:0]     en_i,
  input  logic [W-1:0]     lvl_i,
  output logic [SLOTS-1:0] code_o
);
  localparam int unsigned CW = $clog2(W + 1);

  always_comb begin
    logic [CW-1:0] seen;
    seen   = '0;
    code_o = '0;
    for (int i = 0; i < W; i++) begin
      if (en_i[i]) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (seen == CW'(s)) code_o[s] = lvl_i[i];
        end
        seen = seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpi_router.sv
module gpi_router
  import gpi_router_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_RAILS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_PINS-1:0]    pins_i,
  input  logic [NUM_PINS-1:0]    pin_en_i,
  input  logic [NUM_PINS-1:0]    pol_low_i,
  input  logic [NUM_PINS-1:0]    fault_sel_i,
  input  logic [NUM_PINS-1:0]    clear_sel_i,
  input  logic [NUM_PINS-1:0]    mgn_en_sel_i,
  input  logic [NUM_PINS-1:0]    mgn_sel_sel_i,
  input  logic [NUM_PINS-1:0]    debug_sel_i,
  input  logic [NUM_RAILS-1:0]   rail_mgn_en_i,
  output logic [NUM_PINS-1:0]    fault_evt_o,
  output logic                   clear_pulse_o,
  output logic [2*NUM_RAILS-1:0] mgn_cmd_o,
  output logic [CODE_W-1:0]      state_code_o,
  output logic                   alert_en_o,
  output logic                   dep_bypass_o
);
  localparam int unsigned ARM_W = $clog2(ARM_CYCLES + 1);

  logic [NUM_PINS-1:0] pin_s, lvl, lvl_q, rose, fell;
  logic [NUM_PINS-1:0] en_pick, sel_pick;
  logic [ARM_W-1:0]    arm_cnt_q;
  logic                armed, debug_on, mgn_on, mgn_low;

  gpi_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pin_s)
  );

  assign lvl = pin_s ^ pol_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= '0;
      arm_cnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (arm_cnt_q != ARM_W'(ARM_CYCLES)) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  // edges are only trusted once the synchronizer holds real pin data
  assign armed = (arm_cnt_q == ARM_W'(ARM_CYCLES));
  assign rose  = lvl & ~lvl_q & pin_en_i;
  assign fell  = ~lvl & lvl_q & pin_en_i;

  assign debug_on      = |(lvl & debug_sel_i & pin_en_i);
  assign fault_evt_o   = (armed && !debug_on) ? (fell & fault_sel_i) : '0;
  assign clear_pulse_o = armed && |(rose & clear_sel_i);
  assign alert_en_o    = !debug_on;
  assign dep_bypass_o  = debug_on;

  gpi_first_set #(.W(NUM_PINS)) u_pick_en (
    .vec_i    (mgn_en_sel_i & pin_en_i),
    .onehot_o (en_pick)
  );

  gpi_first_set #(.W(NUM_PINS)) u_pick_sel (
    .vec_i    (mgn_sel_sel_i & pin_en_i),
    .onehot_o (sel_pick)
  );

  assign mgn_on  = |(en_pick & lvl);
  assign mgn_low = |(sel_pick & lvl);

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    mgn_cmd_e cmd;
    always_comb begin
      if (!mgn_on || !rail_mgn_en_i[r]) cmd = MGN_NOMINAL;
      else if (mgn_low)                 cmd = MGN_LOW;
      else                              cmd = MGN_HIGH;
    end
    assign mgn_cmd_o[2*r +: 2] = cmd;
  end

  gpi_code_pick #(.W(NUM_PINS), .SLOTS(CODE_W)) u_code (
    .en_i   (pin_en_i),
    .lvl_i  (lvl),
    .code_o (state_code_o)
  );
endmodule

// File: rtl/gpi_router_chk.sv
module gpi_router_chk #(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned NUM_RAILS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_PINS-1:0]    pin_en_i,
  input logic [NUM_PINS-1:0]    fault_sel_i,
  input logic [NUM_RAILS-1:0]   rail_mgn_en_i,
  input logic [NUM_PINS-1:0]    fault_evt_o,
  input logic                   clear_pulse_o,
  input logic [2*NUM_RAILS-1:0] mgn_cmd_o,
  input logic                   alert_en_o,
  input logic                   dep_bypass_o
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 1'b1;
  end

  a_r3_fault_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_evt_o != '0) |=> ((fault_evt_o & $past(fault_evt_o)) == '0));

  a_r4_clear_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_pulse_o |=> !clear_pulse_o);

  a_r9_debug_blanks_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_en_o |-> (fault_evt_o == '0));

  a_r9_bypass_pairs_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_bypass_o != alert_en_o);

  a_r10_fault_only_defined: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_evt_o & ~(fault_sel_i & pin_en_i)) == '0);

  a_r11_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q != 2'd3) |-> (fault_evt_o == '0 && !clear_pulse_o));

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail_chk
    a_r6_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mgn_cmd_o[2*r +: 2] != 2'b11);
    a_r6_disabled_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rail_mgn_en_i[r] |-> (mgn_cmd_o[2*r +: 2] == 2'b00));
  end
endmodule

bind gpi_router gpi_router_chk #(.NUM_PINS(NUM_PINS), .NUM_RAILS(NUM_RAILS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pin_en_i      (pin_en_i),
  .fault_sel_i   (fault_sel_i),
  .rail_mgn_en_i (rail_mgn_en_i),
  .fault_evt_o   (fault_evt_o),
  .clear_pulse_o (clear_pulse_o),
  .mgn_cmd_o     (mgn_cmd_o),
  .alert_en_o    (alert_en_o),
  .dep_bypass_o  (dep_bypass_o)
);

// File: tb/gpi_router_tb_top.sv
`timescale 1ns/1ps
module gpi_router_tb_top;
  localparam int NP = 32;
  localparam int NR = 4;

  localparam int K_FAULT = 0, K_CLEAR = 1, K_MGN = 2, K_CODE = 3, K_ALERT = 4, K_BYP = 5;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NP-1:0]   pins;
  logic [NP-1:0]   pin_en, pol_low, fault_sel, clear_sel, mgn_en_sel, mgn_sel_sel, debug_sel;
  logic [NR-1:0]   rail_mgn_en;
  logic [NP-1:0]   fault_evt;
  logic            clear_pulse;
  logic [2*NR-1:0] mgn_cmd;
  logic [2:0]      state_code;
  logic            alert_en, dep_bypass;

  item_t q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  // pin map: 0,2,3 form the code (1 undefined); 2,9 active low
  localparam logic [NP-1:0] IDLE = (1 << 4) | (1 << 2);
  localparam logic [NP-1:0] P0 = 1, P1 = 1 << 1, P2 = 1 << 2, P3 = 1 << 3, P4 = 1 << 4,
                            P5 = 1 << 5, P6 = 1 << 6, P7 = 1 << 7, P8 = 1 << 8,
                            P9 = 1 << 9, P10 = 1 << 10, P11 = 1 << 11;

  always #2 clk = ~clk;

  gpi_router #(.NUM_PINS(NP), .NUM_RAILS(NR)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pins_i        (pins),
    .pin_en_i      (pin_en),
    .pol_low_i     (pol_low),
    .fault_sel_i   (fault_sel),
    .clear_sel_i   (clear_sel),
    .mgn_en_sel_i  (mgn_en_sel),
    .mgn_sel_sel_i (mgn_sel_sel),
    .debug_sel_i   (debug_sel),
    .rail_mgn_en_i (rail_mgn_en),
    .fault_evt_o   (fault_evt),
    .clear_pulse_o (clear_pulse),
    .mgn_cmd_o     (mgn_cmd),
    .state_code_o  (state_code),
    .alert_en_o    (alert_en),
    .dep_bypass_o  (dep_bypass)
  );

  function automatic logic [63:0] actual(int kind);
    case (kind)
      K_FAULT: return 64'(fault_evt);
      K_CLEAR: return 64'(clear_pulse);
      K_MGN:   return 64'(mgn_cmd);
      K_CODE:  return 64'(state_code);
      K_ALERT: return 64'(alert_en);
      default: return 64'(dep_bypass);
    endcase
  endfunction

  // monitor: compares each expectation as soon as the driver posts it
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      wait (q.size() != 0);
      it  = q.pop_front();
      act = actual(it.kind);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_v(int kind, logic [63:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive at negedge, sample two rising edges later
  task automatic step(logic [NP-1:0] p);
    @(negedge clk);
    pins = p;
    tick();
    tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [NP-1:0] p;
    pin_en      = ~P1;
    pol_low     = P2 | P9;
    fault_sel   = P4 | P9 | P1;
    clear_sel   = P5;
    mgn_en_sel  = P6 | P7;
    mgn_sel_sel = P8 | P10;
    debug_sel   = P11;
    rail_mgn_en = 4'b1011;
    pins        = IDLE | P5;

    #9;
    expect_v(K_FAULT, 0, "reset fault");
    expect_v(K_CLEAR, 0, "reset clear");
    expect_v(K_MGN, 0, "reset mgn");
    expect_v(K_ALERT, 1, "reset alert_en");
    expect_v(K_BYP, 0, "reset bypass");

    @(negedge clk);
    rst_ni = 1'b1;
    // R11: pin5 already asserted, its synchronized rise must not pulse
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_v(K_CLEAR, 0, "R11 no clear in arm window");
      expect_v(K_FAULT, 0, "R11 no fault in arm window");
    end
    step(IDLE);
    expect_v(K_CLEAR, 0, "R4 falling edge no clear");
    expect_v(K_CODE, 0, "R8 idle code");

    // R8, R2, R10 state code
    step(IDLE | P0 | P3);
    expect_v(K_CODE, 3'b101, "R8 code pins 0,3");
    step((IDLE & ~P2) | P0 | P3);
    expect_v(K_CODE, 3'b111, "R2 active-low pin2 asserted in code");
    step((IDLE & ~P2) | P0 | P3 | P1);
    expect_v(K_CODE, 3'b111, "R10 undefined pin1 skipped in code");
    expect_v(K_FAULT, 0, "R10 undefined pin no fault");
    step((IDLE & ~P2) | P3);
    expect_v(K_CODE, 3'b110, "R8 code pin0 dropped");
    step(IDLE);
    expect_v(K_FAULT, 0, "R10 undefined fault pin released");
    expect_v(K_CODE, 0, "R8 code back to idle");

    // R3 fault events
    step(IDLE & ~P4);
    expect_v(K_FAULT, 64'(P4), "R3 fault on de-assert");
    tick();
    expect_v(K_FAULT, 0, "R3 fault lasts one cycle");
    step(IDLE);
    expect_v(K_FAULT, 0, "R3 no fault on assert");
    step(IDLE | P9);
    expect_v(K_FAULT, 64'(P9), "R2 active-low fault pin de-assert");
    step(IDLE);
    expect_v(K_FAULT, 0, "R3 active-low re-assert no fault");

    // R4 clear pulse
    step(IDLE | P5);
    expect_v(K_CLEAR, 1, "R4 clear on assert");
    tick();
    expect_v(K_CLEAR, 0, "R4 clear lasts one cycle");
    step(IDLE);
    expect_v(K_CLEAR, 0, "R4 no clear on de-assert");

    // R1 latency then margin behaviour
    @(negedge clk);
    pins = IDLE | P6;
    tick();
    expect_v(K_MGN, 0, "R1 unchanged after one edge");
    tick();
    expect_v(K_MGN, 8'h8A, "R1 R6 margin high after two edges");
    step(IDLE | P6 | P8);
    expect_v(K_MGN, 8'h45, "R6 margin low");
    step(IDLE | P6 | P10);
    expect_v(K_MGN, 8'h8A, "R7 non-lowest select pin ignored");
    step(IDLE | P7 | P8);
    expect_v(K_MGN, 0, "R5 non-lowest enable pin ignored");
    step(IDLE | P8);
    expect_v(K_MGN, 0, "R6 nominal without enable");
    step(IDLE);

    // R9 debug override
    step(IDLE | P11);
    expect_v(K_ALERT, 0, "R9 alert disabled in debug");
    expect_v(K_BYP, 1, "R9 bypass in debug");
    step((IDLE & ~P4) | P11);
    expect_v(K_FAULT, 0, "R9 fault blanked in debug");
    tick();
    expect_v(K_FAULT, 0, "R9 fault blanked next cycle");
    p = IDLE | P11;
    step(p);
    step(IDLE);
    expect_v(K_ALERT, 1, "R9 alert restored");
    expect_v(K_BYP, 0, "R9 bypass released");

    done = 1;
    finish_run();
  end
endmodule